// File: doc/BRIEF.md
# Receive Frame Boundary Marker Generator

This block sits on the receive data path after lane alignment and character decoding. It takes a stream of words. Each word holds `LANES` bytes, and byte lane j sits in bits `8j+7:8j`. Lane 0 is the earliest byte in time. For each word the block reports which byte lanes begin a frame and which byte lanes end one. Frames are `F` bytes long, and `F` is set at run time through a frame-length input that carries `F-1`. Because `F` need not divide the word width, frames can straddle word boundaries, and one word can carry several frame starts and several frame ends.

A one-cycle start pulse, given with the first valid word of the data phase, sets the frame position to zero at byte lane 0. From then on the block keeps a running byte offset between words. The offset only advances on valid words, so gaps in the valid signal do not disturb the frame alignment. The data word and its valid flag pass through unchanged, and the markers are aligned to them. All of these outputs appear a fixed `LATENCY` cycles after the input.

Top module: `frame_marker_gen`

## Requirements
- R1: While reset is active, and on the first sample after it is released, `valid_o`, `sof_o` and `eof_o` are all zero.
- R2: `data_o` and `valid_o` equal `data_i` and `valid_i` delayed by exactly `LATENCY` clock cycles, and the data bits are unchanged.
- R3: Bit j of `sof_o` or `eof_o` refers to byte lane j (bits `8j+7:8j`), and lane 0 comes first in time. For F=7 the second word of a data phase yields sof `1000` and eof `0100`: its three low bytes end the previous frame and bits 31:24 start a new frame.
- R4: A word that has both `start_i` and `valid_i` high puts frame position 0 at byte lane 0, so `sof_o[0]=1`. This holds whatever offset was reached before.
- R5: After reset and before the first start pulse, valid words carry all-zero markers.
- R6: Within a word, `eof_o[j]` equals `sof_o[j+1]`. An `eof_o[LANES-1]` is always followed by `sof_o[0]` in the next valid word.
- R7: With frame-length input 0 (F=1), every valid word has sof `1111` and eof `1111`.
- R8: With frame-length input 1 (F=2), every valid word has sof `0101` and eof `1010`.
- R9: With frame-length input 2 (F=3), frames straddle words. Successive valid words give sof/eof pairs `1001/0100`, `0100/0010` and `0010/1001`, and the cycle then repeats.
- R10: The markers are all zero whenever `valid_o` is low. The frame offset is held across cycles where `valid_i` is low.
- R11: Frames longer than one word are marked correctly. With frame-length input 5 (F=6), successive words give `0001/0000`, `0100/0010` and `0000/1000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Data-phase start pulse, qualified by `valid_i` |
| valid_i | input | 1 | Input word valid |
| frame_len_m1_i | input | CNT_W (8) | Frame length F minus one |
| data_i | input | 8*LANES (32) | Input data word |
| valid_o | output | 1 | Delayed valid |
| data_o | output | 8*LANES (32) | Delayed data word |
| sof_o | output | LANES (4) | Start-of-frame marker per byte lane |
| eof_o | output | LANES (4) | End-of-frame marker per byte lane |

## Verification
The assertions check the structural properties on every cycle. Markers are zero when valid is low. Each end marker is matched by a start marker in the next lane, both within a word and across a word boundary to the next valid word, and the reverse relation also holds. These checks cannot show that frames sit at the right byte offsets for a given F. Only the bench's scenarios show that: the placement after a start pulse, a restart in the middle of a frame, the idle state before the first start, and the exact pass-through latency.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;
endpackage

// File: rtl/fbm_lane_pos.sv
module fbm_lane_pos #(
   parameter int unsigned CNT_W = 8
) (
   input  logic [CNT_W-1:0] pos_i,
   input  logic [CNT_W-1:0] last_i,
   output logic             is_first_o,
   output logic             is_last_o,
   output logic [CNT_W-1:0] pos_next_o
);
   always_comb begin
      is_first_o = (pos_i == '0);
      is_last_o  = (pos_i >= last_i);
      pos_next_o = is_last_o ? '0 : pos_i + 1'b1;
   end
endmodule

// File: rtl/fbm_offset_tracker.sv
module fbm_offset_tracker #(
   parameter int unsigned LANES = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   input  logic [CNT_W-1:0] last_i,
   output logic [LANES-1:0] sof_o,
   output logic [LANES-1:0] eof_o
);
   import fbm_pkg::*;

   phase_t           phase_q;
   logic [CNT_W-1:0] base_q;
   logic [CNT_W-1:0] pos [LANES+1];
   logic [LANES-1:0] first_raw;
   logic [LANES-1:0] last_raw;
   logic             take;

   assign take   = valid_i && (start_i || (phase_q == PH_RUN));
   assign pos[0] = start_i ? '0 : base_q;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      fbm_lane_pos #(.CNT_W(CNT_W)) u_pos (
         .pos_i      (pos[j]),
         .last_i     (last_i),
         .is_first_o (first_raw[j]),
         .is_last_o  (last_raw[j]),
         .pos_next_o (pos[j+1])
      );
   end

   always_comb begin
      sof_o = take ? first_raw : '0;
      eof_o = take ? last_raw  : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         base_q  <= '0;
      end else if (take) begin
         phase_q <= PH_RUN;
         base_q  <= pos[LANES];
      end
   end
endmodule

// File: rtl/fbm_pipe.sv
module fbm_pipe #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/frame_marker_gen.sv
module frame_marker_gen #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned MAX_F   = 256,
   parameter int unsigned LATENCY = 2,
   localparam int unsigned CNT_W  = (MAX_F > 1) ? $clog2(MAX_F) : 1,
   localparam int unsigned DATA_W = LANES * fbm_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              valid_i,
   input  logic [CNT_W-1:0]  frame_len_m1_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic [LANES-1:0]  sof_o,
   output logic [LANES-1:0]  eof_o
);
   localparam int unsigned PAY_W = 1 + 2 * LANES + DATA_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("frame_marker_gen: LANES must be at least 1");
   end
   if (MAX_F < 1) begin : g_bad_maxf
      $error("frame_marker_gen: MAX_F must be at least 1");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("frame_marker_gen: LATENCY must be at least 1");
   end

   logic [LANES-1:0] sof_c;
   logic [LANES-1:0] eof_c;
   logic [PAY_W-1:0] pay_in;
   logic [PAY_W-1:0] pay_out;

   fbm_offset_tracker #(.LANES(LANES), .CNT_W(CNT_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .valid_i (valid_i),
      .last_i  (frame_len_m1_i),
      .sof_o   (sof_c),
      .eof_o   (eof_c)
   );

   assign pay_in = {valid_i, sof_c, eof_c, data_i};

   fbm_pipe #(.W(PAY_W), .DEPTH(LATENCY)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pay_in),
      .q_o   (pay_out)
   );

   assign {valid_o, sof_o, eof_o, data_o} = pay_out;
endmodule

// File: rtl/fbm_checker.sv
module fbm_checker #(
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_o,
   input logic [LANES-1:0] sof_o,
   input logic [LANES-1:0] eof_o
);
   logic eof_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eof_pend_q <= 1'b0;
      else if (valid_o) eof_pend_q <= eof_o[LANES-1];
   end

   // R10: markers quiet on invalid words
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (sof_o == '0 && eof_o == '0));

   // R6: last lane end carries into first lane start of next valid word
   assert_cross_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && eof_pend_q) |-> sof_o[0]);

   if (LANES > 1) begin : g_multi
      // R6: end in lane j implies start in lane j+1
      assert_eof_then_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> ((eof_o[LANES-2:0] & ~sof_o[LANES-1:1]) == '0));
      // R6: start in lane j+1 implies end in lane j
      assert_sof_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> ((sof_o[LANES-1:1] & ~eof_o[LANES-2:0]) == '0));
   end
endmodule

bind frame_marker_gen fbm_checker #(.LANES(LANES)) u_fbm_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid_o (valid_o),
   .sof_o   (sof_o),
   .eof_o   (eof_o)
);

// File: tb/test_frame_marker_gen.sv
module test_frame_marker_gen;
   localparam int LAT = 2;
   localparam int NV  = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        valid_i = 1'b0;
   logic [7:0]  frame_len_m1_i = '0;
   logic [31:0] data_i = '0;
   logic        valid_o;
   logic [31:0] data_o;
   logic [3:0]  sof_o;
   logic [3:0]  eof_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   frame_marker_gen #(.LANES(4), .MAX_F(256), .LATENCY(LAT)) i_frame_marker_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
      .frame_len_m1_i(frame_len_m1_i), .data_i(data_i),
      .valid_o(valid_o), .data_o(data_o), .sof_o(sof_o), .eof_o(eof_o)
   );

   // {req id, start, valid, F-1, expected sof, expected eof}
   localparam logic [21:0] VEC [NV] = '{
      {4'd9,  1'b1, 1'b1, 8'd2, 4'b1001, 4'b0100},
      {4'd9,  1'b0, 1'b1, 8'd2, 4'b0100, 4'b0010},
      {4'd10, 1'b0, 1'b0, 8'd2, 4'b0000, 4'b0000},
      {4'd10, 1'b0, 1'b1, 8'd2, 4'b0010, 4'b1001},
      {4'd9,  1'b0, 1'b1, 8'd2, 4'b1001, 4'b0100},
      {4'd8,  1'b1, 1'b1, 8'd1, 4'b0101, 4'b1010},
      {4'd8,  1'b0, 1'b1, 8'd1, 4'b0101, 4'b1010},
      {4'd7,  1'b1, 1'b1, 8'd0, 4'b1111, 4'b1111},
      {4'd7,  1'b0, 1'b1, 8'd0, 4'b1111, 4'b1111},
      {4'd11, 1'b1, 1'b1, 8'd5, 4'b0001, 4'b0000},
      {4'd11, 1'b0, 1'b1, 8'd5, 4'b0100, 4'b0010},
      {4'd11, 1'b0, 1'b1, 8'd5, 4'b0000, 4'b1000},
      {4'd11, 1'b0, 1'b1, 8'd5, 4'b0001, 4'b0000},
      {4'd4,  1'b1, 1'b1, 8'd3, 4'b0001, 4'b1000},
      {4'd6,  1'b0, 1'b1, 8'd3, 4'b0001, 4'b1000},
      {4'd4,  1'b1, 1'b1, 8'd2, 4'b1001, 4'b0100},
      {4'd11, 1'b1, 1'b1, 8'd6, 4'b0001, 4'b0000},
      {4'd3,  1'b0, 1'b1, 8'd6, 4'b1000, 4'b0100}
   };

   function automatic string req_name(input logic [3:0] id);
      case (id)
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         4'd10:   return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [31:0] pattern(input int k);
      return 32'h5A3C_0F00 ^ (k * 32'h0101_0103);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", {31'd0, valid_o}, 32'd0);
      chk("R1", {28'd0, sof_o}, 32'd0);
      chk("R1", {28'd0, eof_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {23'd0, valid_o, sof_o, eof_o}, 32'd0);

      // R5: valid words before any start pulse carry no markers
      for (int m = 0; m < 3 + LAT; m++) begin
         if (m >= LAT) begin
            chk("R5", {31'd0, valid_o}, 32'd1);
            chk("R5", {24'd0, sof_o, eof_o}, 32'd0);
         end
         valid_i = (m < 3);
         frame_len_m1_i = 8'd2;
         data_i = pattern(100 + m);
         @(negedge clk);
      end
      valid_i = 1'b0;
      repeat (LAT) @(negedge clk);

      // table walk: R2 on data/valid, per-vector requirement on markers
      for (int m = 0; m < NV + LAT; m++) begin
         if (m >= LAT) begin
            chk("R2", data_o, pattern(m - LAT));
            chk("R2", {31'd0, valid_o}, {31'd0, VEC[m-LAT][16]});
            chk(req_name(VEC[m-LAT][21:18]), {24'd0, sof_o, eof_o},
                {24'd0, VEC[m-LAT][7:0]});
         end
         if (m < NV) begin
            start_i        = VEC[m][17];
            valid_i        = VEC[m][16];
            frame_len_m1_i = VEC[m][15:8];
         end else begin
            start_i = 1'b0;
            valid_i = 1'b0;
         end
         data_i = pattern(m);
         @(negedge clk);
      end

      // R10: outputs quiet after the stream drains
      chk("R10", {23'd0, valid_o, sof_o, eof_o}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule